// File: doc/BRIEF.md
# Device Register Bank with Sticky Event Flags

This block sits behind a packet slave that turns a serial host link into a byte stream. Each packet opens while `pkt_sel_i` is high. The first byte accepted in a packet is a command code, and bit 7 of that code sets the direction. When bit 7 is 1, the following bytes are payload flowing into the block. When bit 7 is 0, the block answers with a stream of response bytes.

The block holds ten 8-bit storage-device registers and a status byte. Bits 0 to 3 of the status byte come straight from live inputs. Bits 4 to 7 are sticky event flags, set by one-cycle strobes from the device-bus side. The host can read or write the whole bank in a fixed order, read the status, clear chosen flags with a mask, read a protocol version, read a link-test ramp, and load the device status register while raising the device interrupt.

Back-pressure follows these rules:
- Inbound bytes move on `rx_valid_i && rx_ready_o`. `rx_ready_o` is high in every cycle of an open packet except the first, and the block never stalls the sender.
- Outbound bytes move on `tx_valid_o && tx_ready_i`. While `tx_ready_i` is low, `tx_data_o` keeps presenting the same byte position.

Top module: `devreg_bank`

## Requirements
- R1: After reset, all ten registers and all four sticky flags are zero. Status byte bit 0 reflects `stat_dir_i`, bit 1 `stat_rx_ready_i`, bit 2 `stat_tx_room_i`, bit 3 `stat_drained_i`, bit 4 bus-reset seen, bit 5 soft-reset seen, bit 6 command register written, and bit 7 any register written.
- R2: A one-cycle strobe on `ev_bus_rst_i`, `ev_soft_rst_i`, `ev_cmd_wr_i` or `ev_reg_wr_i` sets status bit 4, 5, 6 or 7 respectively. The bit then stays set until it is cleared.
- R3: Command 0x92 takes its first payload byte as a mask. A 1 in mask bit 4 to 7 clears the status bit at the same position. Mask bits 0 to 3 and any later payload bytes have no effect.
- R4: When a strobe and a clear of the same flag land in the same cycle, the flag ends up set.
- R5: Command 0x00 returns the status byte, then register 0 (device status), then zeros.
- R6: Command 0x81 writes payload byte k into register k, and command 0x01 returns register k as response byte k. The register order is: 0 status, 1 command, 2 device, 3 device control, 4 error, 5 feature, 6 sector count, 7 LBA low, 8 LBA mid, 9 LBA high. Payload bytes past the tenth are discarded, and response bytes past the tenth are zero.
- R7: Command 0x7F returns the bytes 0, 1, ..., 255 in order, then zeros.
- R8: Command 0x7D returns the nonzero `VERSION` parameter (default 5), then zeros.
- R9: Command 0x91 writes its first payload byte into register 0. `irq_o` is high for exactly the one cycle after that byte is accepted. Later payload bytes have no effect.
- R10: Any other command code answers with zero bytes if bit 7 is 0, and ignores its payload if bit 7 is 1.
- R11: The first accepted byte of a packet is the command. `tx_valid_o` is high only in a read packet after its command, and it falls within one cycle of `pkt_sel_i` going low. Inbound bytes during a read packet are discarded. A stalled response byte is presented again unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_sel_i | input | 1 | High while a packet is open |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_ready_o | output | 1 | Inbound byte accepted when high |
| rx_data_i | input | 8 | Inbound byte |
| tx_valid_o | output | 1 | Response byte valid |
| tx_ready_i | input | 1 | Response byte taken when high |
| tx_data_o | output | 8 | Response byte |
| stat_dir_i | input | 1 | Live status bit 0 |
| stat_rx_ready_i | input | 1 | Live status bit 1 |
| stat_tx_room_i | input | 1 | Live status bit 2 |
| stat_drained_i | input | 1 | Live status bit 3 |
| ev_bus_rst_i | input | 1 | Bus-reset event strobe |
| ev_soft_rst_i | input | 1 | Software-reset event strobe |
| ev_cmd_wr_i | input | 1 | Command-register-written strobe |
| ev_reg_wr_i | input | 1 | Any-register-written strobe |
| irq_o | output | 1 | Device interrupt pulse |

## Verification
Most faults in this block stay hidden until the host asks for the state they touched, so the first symptom appears as a wrong byte in a later read packet. A byte index that is off by one shows up at once as a shifted register order in a bulk read, or as a ramp that starts at 1. A flag that was lost or cleared by mistake shows up at the next status read. A wrong register write stays invisible until a read of the bank. Only the interrupt and the handshake signals can show a fault in the very next cycle.

// File: rtl/devreg_pkg.sv
package devreg_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 9;
  localparam logic [IDX_W-1:0] IDX_MAX = 9'd256;

  localparam logic [7:0] OP_STATUS  = 8'h00;
  localparam logic [7:0] OP_RD_REGS = 8'h01;
  localparam logic [7:0] OP_VERSION = 8'h7D;
  localparam logic [7:0] OP_RAMP    = 8'h7F;
  localparam logic [7:0] OP_WR_REGS = 8'h81;
  localparam logic [7:0] OP_IRQ_ST  = 8'h91;
  localparam logic [7:0] OP_CLR     = 8'h92;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/devreg_flags.sv
module devreg_flags #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flags_q;

  // event beats clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | ev_i;
  end

  assign flags_o = flags_q;

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((flags_o & $past(ev_i)) == $past(ev_i)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i != '0) && ((clr_i & ev_i) == '0)) |=> ((flags_o & $past(clr_i)) == '0));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i == '0) && (ev_i == '0)) |=> $stable(flags_o));
endmodule

// File: rtl/devreg_regfile.sv
module devreg_regfile
  import devreg_pkg::*;
#(
  parameter int NREG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] reg0_o
);
  localparam logic [IDX_W-1:0] NUM = IDX_W'(NREG);

  logic [BYTE_W-1:0] regs_q [NREG];
  logic              in_range;

  assign in_range = (idx_i < NUM);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    regs_q[g] <= '0;
      else if (we_i && in_range && idx_i == IDX_W'(g)) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREG; k++)
      if (idx_i == IDX_W'(k)) rdata_o = regs_q[k];
  end

  assign reg0_o = regs_q[0];

  p_write_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (idx_i < NUM));
endmodule

// File: rtl/devreg_cmd.sv
module devreg_cmd
  import devreg_pkg::*;
#(
  parameter int          NREG    = 10,
  parameter logic [7:0]  VERSION = 8'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_sel_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  input  logic [BYTE_W-1:0] reg0_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [3:0]        clr_o,
  output logic              irq_o
);
  localparam logic [IDX_W-1:0] NUM = IDX_W'(NREG);

  seq_state_t        st_q;
  logic [7:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic              irq_q;
  logic              rx_fire, tx_fire, wr_fire;

  assign rx_ready_o = pkt_sel_i && (st_q != ST_IDLE);
  assign tx_valid_o = (st_q == ST_RD);
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign tx_fire    = tx_valid_o && tx_ready_i;
  assign wr_fire    = (st_q == ST_WR) && rx_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      idx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= wr_fire && (op_q == OP_IRQ_ST) && (idx_q == '0);
      if (!pkt_sel_i) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: st_q <= ST_CMD;
          ST_CMD: if (rx_fire) begin
            op_q  <= rx_data_i;
            idx_q <= '0;
            st_q  <= rx_data_i[7] ? ST_WR : ST_RD;
          end
          ST_WR: if (rx_fire && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
          ST_RD: if (tx_fire && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    reg_we_o = wr_fire && (((op_q == OP_WR_REGS) && (idx_q < NUM)) ||
                           ((op_q == OP_IRQ_ST) && (idx_q == '0)));
    clr_o    = (wr_fire && (op_q == OP_CLR) && (idx_q == '0)) ? rx_data_i[7:4] : 4'h0;
  end

  always_comb begin
    tx_data_o = '0;
    unique case (op_q)
      OP_STATUS:  tx_data_o = (idx_q == 9'd0) ? status_i :
                              (idx_q == 9'd1) ? reg0_i : '0;
      OP_RD_REGS: tx_data_o = reg_rdata_i;
      OP_VERSION: tx_data_o = (idx_q == 9'd0) ? VERSION : '0;
      OP_RAMP:    tx_data_o = (idx_q < IDX_MAX) ? idx_q[7:0] : '0;
      default:    tx_data_o = '0;
    endcase
  end

  assign idx_o = idx_q;
  assign irq_o = irq_q;

  p_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_sel_i |=> !tx_valid_o);
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && pkt_sel_i) |=> ($stable(idx_q) && tx_valid_o));
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(reg_we_o) && $past(op_q) == OP_IRQ_ST));
endmodule

// File: rtl/devreg_bank.sv
module devreg_bank
  import devreg_pkg::*;
#(
  parameter int         NREG    = 10,
  parameter logic [7:0] VERSION = 8'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_sel_i,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  input  logic       stat_dir_i,
  input  logic       stat_rx_ready_i,
  input  logic       stat_tx_room_i,
  input  logic       stat_drained_i,
  input  logic       ev_bus_rst_i,
  input  logic       ev_soft_rst_i,
  input  logic       ev_cmd_wr_i,
  input  logic       ev_reg_wr_i,
  output logic       irq_o
);
  logic [3:0]        flags, clr;
  logic [BYTE_W-1:0] status, reg_rdata, reg0;
  logic              reg_we;
  logic [IDX_W-1:0]  idx;

  assign status = {flags, stat_drained_i, stat_tx_room_i, stat_rx_ready_i, stat_dir_i};

  devreg_flags #(.NFLAG(4)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_i({ev_reg_wr_i, ev_cmd_wr_i, ev_soft_rst_i, ev_bus_rst_i}),
    .clr_i(clr), .flags_o(flags)
  );

  devreg_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .idx_i(idx),
    .wdata_i(rx_data_i), .rdata_o(reg_rdata), .reg0_o(reg0)
  );

  devreg_cmd #(.NREG(NREG), .VERSION(VERSION)) u_cmd (
    .clk(clk), .rst_n(rst_n), .pkt_sel_i(pkt_sel_i),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .status_i(status), .reg_rdata_i(reg_rdata), .reg0_i(reg0),
    .reg_we_o(reg_we), .idx_o(idx), .clr_o(clr), .irq_o(irq_o)
  );
endmodule

// File: tb/devreg_bank_tb.sv
module devreg_bank_tb;
  logic clk = 0, rst_n = 0;
  logic pkt_sel = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic [3:0] st_in = 0, ev = 0;
  logic rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_regs [10];
  logic [7:0] m_flags;

  always #4 clk = ~clk;

  devreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_sel_i(pkt_sel),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .stat_dir_i(st_in[0]), .stat_rx_ready_i(st_in[1]),
    .stat_tx_room_i(st_in[2]), .stat_drained_i(st_in[3]),
    .ev_bus_rst_i(ev[0]), .ev_soft_rst_i(ev[1]),
    .ev_cmd_wr_i(ev[2]), .ev_reg_wr_i(ev[3]), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_flags[7:4], st_in};
  endfunction

  task automatic start_pkt();
    @(negedge clk) pkt_sel = 1;
  endtask

  task automatic end_pkt();
    @(negedge clk) begin pkt_sel = 0; tx_ready = 0; end
    @(negedge clk);
    chk(!tx_valid && !rx_ready, "R11 idle after close", {tx_valid, rx_ready}, 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1; rx_data = b; end
    @(posedge clk);
    #1 rx_valid = 0;
  endtask

  task automatic read_chk(input logic [7:0] exp, input string req);
    if ($urandom % 4 == 0) begin
      @(negedge clk) tx_ready = 0;
      #1 chk(tx_valid === 1'b1 && tx_data === exp, {req, " stalled"}, tx_data, exp);
    end
    @(negedge clk) tx_ready = 1;
    #1 chk(tx_valid === 1'b1 && tx_data === exp, req, tx_data, exp);
    @(posedge clk);
    #1 tx_ready = 0;
  endtask

  task automatic pulse_ev(input logic [3:0] m);
    @(negedge clk) ev = m;
    @(negedge clk) ev = 0;
    m_flags[7:4] |= m;
  endtask

  task automatic read_status();
    st_in = 4'($urandom);
    start_pkt();
    send_byte(8'h00);
    read_chk(exp_status(), "R5 status byte");
    read_chk(m_regs[0], "R5 device status");
    read_chk(8'h00, "R5 trailing zero");
    end_pkt();
  endtask

  task automatic read_regs();
    start_pkt();
    send_byte(8'h01);
    for (int i = 0; i < 12; i++)
      read_chk(i < 10 ? m_regs[i] : 8'h00, "R6 bank read");
    end_pkt();
  endtask

  task automatic write_regs(input int n);
    start_pkt();
    send_byte(8'h81);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      send_byte(b);
      if (i < 10) m_regs[i] = b;
    end
    end_pkt();
  endtask

  task automatic clear_flags(input logic [7:0] m, input logic [3:0] evm);
    start_pkt();
    send_byte(8'h92);
    @(negedge clk) begin rx_valid = 1; rx_data = m; ev = evm; end
    @(posedge clk);
    #1 begin rx_valid = 0; ev = 0; end
    m_flags[7:4] = (m_flags[7:4] & ~m[7:4]) | evm;
    send_byte(8'hF0);
    end_pkt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_flags = 0;
    for (int i = 0; i < 10; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !rx_ready && !irq, "R1 reset outputs", {tx_valid, rx_ready, irq}, 0);
    read_status();
    read_regs();

    // R2 each flag sticks
    for (int i = 0; i < 4; i++) begin
      pulse_ev(4'(1 << i));
      read_status();
    end
    // R3 low mask bits ignored, high bits clear
    clear_flags(8'h0F, 4'h0);
    read_status();
    clear_flags(8'h50, 4'h0);
    read_status();
    // R4 event wins over simultaneous clear
    clear_flags(8'hF0, 4'hA);
    read_status();

    // R6 full write, over-long write
    write_regs(10);
    read_regs();
    write_regs(13);
    read_regs();

    // R7 ramp
    start_pkt();
    send_byte(8'h7F);
    for (int i = 0; i < 258; i++)
      read_chk(i < 256 ? 8'(i) : 8'h00, "R7 ramp");
    end_pkt();

    // R8 version
    start_pkt();
    send_byte(8'h7D);
    read_chk(8'd5, "R8 version");
    read_chk(8'd0, "R8 trailing zero");
    end_pkt();

    // R9 status write with interrupt
    start_pkt();
    send_byte(8'h91);
    chk(irq === 1'b0, "R9 no irq on command byte", irq, 0);
    send_byte(8'h3C);
    m_regs[0] = 8'h3C;
    chk(irq === 1'b1, "R9 irq pulse", irq, 1);
    @(posedge clk);
    #1 chk(irq === 1'b0, "R9 irq one cycle", irq, 0);
    send_byte(8'h99);
    chk(irq === 1'b0, "R9 second byte no irq", irq, 0);
    end_pkt();
    read_status();

    // R10 unknown codes
    start_pkt();
    send_byte(8'hA5);
    send_byte(8'h11);
    send_byte(8'h22);
    end_pkt();
    read_regs();
    start_pkt();
    send_byte(8'h33);
    for (int i = 0; i < 4; i++) read_chk(8'h00, "R10 unknown read");
    end_pkt();

    // R11 inbound bytes during read packet discarded
    start_pkt();
    send_byte(8'h01);
    send_byte(8'h81);
    send_byte(8'h77);
    for (int i = 0; i < 10; i++) read_chk(m_regs[i], "R11 rx ignored in read");
    end_pkt();

    // random mix
    for (int it = 0; it < 120; it++) begin
      case ($urandom % 5)
        0: write_regs(int'($urandom % 14));
        1: read_regs();
        2: pulse_ev(4'($urandom));
        3: clear_flags(8'($urandom), 4'($urandom % 3 == 0 ? $urandom : 0));
        default: read_status();
      endcase
    end
    read_status();
    read_regs();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule